// File: doc/BRIEF.md
# Slave-Select Controller with Single-Reader Rule and Echo Check

This block sits next to an SPI shift engine and owns four active-low slave-select lines. A host presents a transfer request that gives a direction (write or read), a mask naming the target slaves, and the byte to shift out. A write may address any set of slaves at once, which allows a broadcast. A read must name exactly one slave, because two slaves that drive the shared return line at the same time would contend. A read request that names no slave, or more than one, is refused and a sticky error flag is raised.

Once a request is accepted, the controller drives the chosen select lines low and sends a one-cycle start pulse with the byte to the shift engine. The lines stay put until the engine reports completion. One clock later they all return high. A request that arrives while a byte is in flight is parked in a one-deep holding slot and launched after the release. An optional echo-check mode compares the byte a slave returns with the byte the master sent on the transfer before. This is useful when slaves are wired to echo what they received. A mismatch latches a sticky flag. The first transfer after the mode is switched on has no earlier byte to compare against, so no comparison is made for it.

Top module: `ss_select_ctrl`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `ss_n` is 4'b1111, `busy`, `shf_start`, `rd_err` and `echo_err` are 0.
- R2: While `busy` is 0, every line of `ss_n` is high.
- R3: An accepted write (`req_write`=1) with any mask, including all four bits, drives `ss_n` to the bitwise inverse of `req_mask` for the whole transfer. Bit i of the mask selects line i.
- R4: A read (`req_write`=0) whose mask has exactly one bit set is accepted and drives `ss_n` to the inverse of the mask.
- R5: A read whose mask has zero bits or two or more bits set starts no transfer. `ss_n` stays 4'b1111, `shf_start` stays 0, and `rd_err` goes to 1 in the next cycle and stays 1 until cleared.
- R6: A request sampled while idle with nothing held gives, in the next cycle, `shf_start`=1 for exactly one cycle, `shf_tx` equal to the request byte, `busy`=1 and the selects asserted.
- R7: A legal request made while `busy` is 1 is held. The held slot is one deep and a later request overwrites an earlier one. `ss_n` does not change until the running transfer ends, and the held request is launched on the second clock edge after `shf_done`.
- R8: A clock edge with `busy`=1 and `shf_done`=1 makes `ss_n` 4'b1111 and `busy` 0 in the next cycle.
- R9: With `echo_en`=1, if the `shf_rx` byte at the end of a transfer differs from the `shf_tx` byte of the previous completed transfer, `echo_err` becomes 1 in the next cycle. It stays 1 until cleared.
- R10: The first transfer that completes after `echo_en` rises is not compared. Holding `echo_en` at 0 for at least one clock edge discards the stored previous byte.
- R11: `flag_clr`=1 clears `rd_err` and `echo_err` in the next cycle. If a flag's set condition occurs in the same cycle, the set wins.
- R12: `shf_done` while `busy` is 0 has no effect on the selects, the flags or the stored previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request strobe, one cycle per request |
| req_write | input | 1 | 1 = write (broadcast allowed), 0 = read (single slave) |
| req_mask | input | 4 | Slave mask, bit i selects line i |
| req_data | input | 8 | Byte to shift out |
| echo_en | input | 1 | Enables the echo comparison |
| flag_clr | input | 1 | Clears both sticky flags |
| shf_start | output | 1 | One-cycle start pulse to the shift engine |
| shf_tx | output | 8 | Byte handed to the shift engine |
| shf_done | input | 1 | Shift engine completion pulse |
| shf_rx | input | 8 | Byte received by the shift engine, valid with shf_done |
| ss_n | output | 4 | Active-low slave-select lines |
| busy | output | 1 | A transfer is in progress |
| rd_err | output | 1 | Sticky: an illegal read request was refused |
| echo_err | output | 1 | Sticky: an echo comparison failed |

## Verification
On every cycle the assertions check the following: all selects are high whenever the block is idle, at most one line is asserted during a read, the selects hold steady through a byte and are released after completion, the start pulse lasts a single cycle, an illegal read raises the error flag, and the sticky flags persist. The bench scenarios show the behaviours that depend on data history or ordering. These are the echo comparison against the previous byte, the skipped first comparison and the discarded history after disabling, overwrite of the held request by a later one, priority of set over clear, and a stray completion pulse while idle leaving the stored byte untouched.

// File: rtl/ss_sel_pkg.sv
package ss_sel_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // a write may target any set; a read needs exactly one target
    function automatic logic dir_permits(input logic is_write, input logic single_target);
        return is_write | single_target;
    endfunction

endpackage

// File: rtl/ss_req_check.sv
module ss_req_check
    import ss_sel_pkg::*;
#(
    parameter int NUM_SS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [NUM_SS-1:0] req_mask,
    input  logic              flag_clr,
    output logic              req_legal,
    output logic              rd_err
);
    localparam int CW = $clog2(NUM_SS + 1);

    logic [CW-1:0] bit_cnt;
    logic          single;
    logic          refused;

    always_comb begin
        bit_cnt = '0;
        for (int i = 0; i < NUM_SS; i++) begin
            bit_cnt = bit_cnt + CW'(req_mask[i]);
        end
    end

    assign single    = (bit_cnt == CW'(1));
    assign req_legal = req_valid & dir_permits(req_write, single);
    assign refused   = req_valid & ~req_legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_err <= 1'b0;
        end else if (refused) begin
            rd_err <= 1'b1;
        end else if (flag_clr) begin
            rd_err <= 1'b0;
        end
    end
endmodule

// File: rtl/ss_hold.sv
module ss_hold #(
    parameter int NUM_SS = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              take,
    input  logic              in_write,
    input  logic [NUM_SS-1:0] in_mask,
    input  logic [DATA_W-1:0] in_data,
    output logic              hold_vld,
    output logic              hold_write,
    output logic [NUM_SS-1:0] hold_mask,
    output logic [DATA_W-1:0] hold_data
);
    typedef struct packed {
        logic              wr;
        logic [NUM_SS-1:0] mask;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            slot_q   <= '0;
        end else begin
            if (load) begin
                hold_vld <= 1'b1;
                slot_q   <= '{wr: in_write, mask: in_mask, data: in_data};
            end else if (take) begin
                hold_vld <= 1'b0;
            end
        end
    end

    assign hold_write = slot_q.wr;
    assign hold_mask  = slot_q.mask;
    assign hold_data  = slot_q.data;
endmodule

// File: rtl/ss_seq.sv
module ss_seq
    import ss_sel_pkg::*;
#(
    parameter int NUM_SS = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              new_legal,
    input  logic              new_write,
    input  logic [NUM_SS-1:0] new_mask,
    input  logic [DATA_W-1:0] new_data,
    input  logic              hold_vld,
    input  logic              hold_write,
    input  logic [NUM_SS-1:0] hold_mask,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              shf_done,
    output logic              take_hold,
    output logic              take_new,
    output logic [NUM_SS-1:0] ss_n,
    output logic              shf_start,
    output logic [DATA_W-1:0] shf_tx,
    output logic              busy,
    output logic              xfer_done,
    output logic              cur_write
);
    seq_state_e        state_q;
    logic              idle;
    logic              launch;
    logic              l_write;
    logic [NUM_SS-1:0] l_mask;
    logic [DATA_W-1:0] l_data;
    logic [NUM_SS-1:0] sel_q;

    assign idle      = (state_q == ST_IDLE);
    assign take_hold = idle & hold_vld;
    assign take_new  = idle & ~hold_vld & new_legal;
    assign launch    = take_hold | take_new;
    assign l_write   = take_hold ? hold_write : new_write;
    assign l_mask    = take_hold ? hold_mask  : new_mask;
    assign l_data    = take_hold ? hold_data  : new_data;
    assign xfer_done = (state_q == ST_RUN) & shf_done;
    assign busy      = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            shf_start <= 1'b0;
            shf_tx    <= '0;
            cur_write <= 1'b0;
        end else begin
            shf_start <= launch;
            if (launch) begin
                state_q   <= ST_RUN;
                shf_tx    <= l_data;
                cur_write <= l_write;
            end else if (xfer_done) begin
                state_q <= ST_IDLE;
            end
        end
    end

    for (genvar g = 0; g < NUM_SS; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[g] <= 1'b0;
            end else if (launch) begin
                sel_q[g] <= l_mask[g];
            end else if (xfer_done) begin
                sel_q[g] <= 1'b0;
            end
        end
        assign ss_n[g] = ~sel_q[g];
    end
endmodule

// File: rtl/ss_echo.sv
module ss_echo #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              echo_en,
    input  logic              flag_clr,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              echo_err
);
    logic [DATA_W-1:0] prev_q;
    logic              have_prev_q;
    logic              miss;

    assign miss = xfer_done & echo_en & have_prev_q & (rx_byte != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            echo_err    <= 1'b0;
        end else begin
            if (xfer_done) begin
                prev_q      <= tx_byte;
                have_prev_q <= echo_en;
            end else if (!echo_en) begin
                have_prev_q <= 1'b0;
            end
            if (miss) begin
                echo_err <= 1'b1;
            end else if (flag_clr) begin
                echo_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ss_select_ctrl.sv
module ss_select_ctrl #(
    parameter int NUM_SS = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [NUM_SS-1:0] req_mask,
    input  logic [DATA_W-1:0] req_data,
    input  logic              echo_en,
    input  logic              flag_clr,
    output logic              shf_start,
    output logic [DATA_W-1:0] shf_tx,
    input  logic              shf_done,
    input  logic [DATA_W-1:0] shf_rx,
    output logic [NUM_SS-1:0] ss_n,
    output logic              busy,
    output logic              rd_err,
    output logic              echo_err
);
    logic              req_legal;
    logic              hold_vld;
    logic              hold_write;
    logic [NUM_SS-1:0] hold_mask;
    logic [DATA_W-1:0] hold_data;
    logic              take_hold;
    logic              take_new;
    logic              hold_load;
    logic              xfer_done;
    logic              cur_write;

    ss_req_check #(.NUM_SS(NUM_SS)) chk_u (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mask  (req_mask),
        .flag_clr  (flag_clr),
        .req_legal (req_legal),
        .rd_err    (rd_err)
    );

    assign hold_load = req_legal & ~take_new;

    ss_hold #(.NUM_SS(NUM_SS), .DATA_W(DATA_W)) hold_u (
        .clk        (clk),
        .rst        (rst),
        .load       (hold_load),
        .take       (take_hold),
        .in_write   (req_write),
        .in_mask    (req_mask),
        .in_data    (req_data),
        .hold_vld   (hold_vld),
        .hold_write (hold_write),
        .hold_mask  (hold_mask),
        .hold_data  (hold_data)
    );

    ss_seq #(.NUM_SS(NUM_SS), .DATA_W(DATA_W)) seq_u (
        .clk        (clk),
        .rst        (rst),
        .new_legal  (req_legal),
        .new_write  (req_write),
        .new_mask   (req_mask),
        .new_data   (req_data),
        .hold_vld   (hold_vld),
        .hold_write (hold_write),
        .hold_mask  (hold_mask),
        .hold_data  (hold_data),
        .shf_done   (shf_done),
        .take_hold  (take_hold),
        .take_new   (take_new),
        .ss_n       (ss_n),
        .shf_start  (shf_start),
        .shf_tx     (shf_tx),
        .busy       (busy),
        .xfer_done  (xfer_done),
        .cur_write  (cur_write)
    );

    ss_echo #(.DATA_W(DATA_W)) echo_u (
        .clk       (clk),
        .rst       (rst),
        .echo_en   (echo_en),
        .flag_clr  (flag_clr),
        .xfer_done (xfer_done),
        .rx_byte   (shf_rx),
        .tx_byte   (shf_tx),
        .echo_err  (echo_err)
    );
endmodule

// File: rtl/ss_sel_chk.sv
module ss_sel_chk #(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [NUM_SS-1:0] req_mask,
    input logic              flag_clr,
    input logic              shf_start,
    input logic              shf_done,
    input logic [NUM_SS-1:0] ss_n,
    input logic              busy,
    input logic              rd_err,
    input logic              echo_err,
    input logic              cur_write
);
    a_r1_reset_release: assert property (@(posedge clk)
        rst |=> (ss_n == '1) && !busy && !shf_start && !rd_err && !echo_err);

    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ss_n == '1));

    a_r4_read_single: assert property (@(posedge clk) disable iff (rst)
        (busy && !cur_write) |-> ($countones(~ss_n) == 1));

    a_r5_bad_read_flag: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && ($countones(req_mask) != 1)) |=> rd_err);

    a_r6_start_single: assert property (@(posedge clk) disable iff (rst)
        shf_start |=> !shf_start);

    a_r7_select_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && !shf_start) |-> $stable(ss_n));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (busy && shf_done) |=> ((ss_n == '1) && !busy));

    a_r9_echo_sticky: assert property (@(posedge clk) disable iff (rst)
        (echo_err && !flag_clr) |=> echo_err);

    a_r5_rd_sticky: assert property (@(posedge clk) disable iff (rst)
        (rd_err && !flag_clr) |=> rd_err);
endmodule

bind ss_select_ctrl ss_sel_chk #(.NUM_SS(NUM_SS)) sel_chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mask  (req_mask),
    .flag_clr  (flag_clr),
    .shf_start (shf_start),
    .shf_done  (shf_done),
    .ss_n      (ss_n),
    .busy      (busy),
    .rd_err    (rd_err),
    .echo_err  (echo_err),
    .cur_write (cur_write)
);

// File: tb/ss_select_ctrl_tb_top.sv
module ss_select_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_write;
    logic [3:0] req_mask;
    logic [7:0] req_data;
    logic       echo_en, flag_clr;
    logic       shf_start;
    logic [7:0] shf_tx;
    logic       shf_done;
    logic [7:0] shf_rx;
    logic [3:0] ss_n;
    logic       busy, rd_err, echo_err;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    ss_select_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mask(req_mask), .req_data(req_data), .echo_en(echo_en),
        .flag_clr(flag_clr), .shf_start(shf_start), .shf_tx(shf_tx),
        .shf_done(shf_done), .shf_rx(shf_rx), .ss_n(ss_n), .busy(busy),
        .rd_err(rd_err), .echo_err(echo_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    // one-cycle request; returns at the negedge after the sampling edge
    task automatic put_req(input logic w, input logic [3:0] m, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_mask = m; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // completion pulse; returns at the negedge after the edge that saw it
    task automatic end_xfer(input logic [7:0] rx);
        @(negedge clk);
        shf_done = 1'b1; shf_rx = rx;
        @(negedge clk);
        shf_done = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] rx);
        put_req(1'b1, 4'b0001, tx);
        end_xfer(rx);
    endtask

    task automatic t_reset();
        chk("R1 ss_n", ss_n, 4'b1111);
        chk("R1 busy", busy, 0);
        chk("R1 start", shf_start, 0);
        chk("R1 rd_err", rd_err, 0);
        chk("R1 echo_err", echo_err, 0);
    endtask

    task automatic t_write();
        put_req(1'b1, 4'b1111, 8'hA5);
        chk("R6 start", shf_start, 1);
        chk("R6 tx", shf_tx, 8'hA5);
        chk("R6 busy", busy, 1);
        chk("R3 broadcast ss_n", ss_n, 4'b0000);
        @(negedge clk);
        chk("R6 start one cycle", shf_start, 0);
        chk("R3 held", ss_n, 4'b0000);
        end_xfer(8'h00);
        chk("R8 release ss_n", ss_n, 4'b1111);
        chk("R8 busy low", busy, 0);
        chk("R2 idle", ss_n, 4'b1111);
        put_req(1'b1, 4'b1010, 8'h3C);
        chk("R3 partial ss_n", ss_n, 4'b0101);
        end_xfer(8'h00);
    endtask

    task automatic t_read_ok();
        put_req(1'b0, 4'b0100, 8'h5A);
        chk("R4 read ss_n", ss_n, 4'b1011);
        chk("R4 start", shf_start, 1);
        chk("R4 rd_err", rd_err, 0);
        end_xfer(8'h00);
        chk("R8 after read", ss_n, 4'b1111);
    endtask

    task automatic t_read_bad();
        put_req(1'b0, 4'b0000, 8'h11);
        chk("R5 none ss_n", ss_n, 4'b1111);
        chk("R5 none start", shf_start, 0);
        chk("R5 none busy", busy, 0);
        chk("R5 none rd_err", rd_err, 1);
        pulse_clr();
        chk("R11 clr rd_err", rd_err, 0);
        put_req(1'b0, 4'b0110, 8'h22);
        chk("R5 two ss_n", ss_n, 4'b1111);
        chk("R5 two start", shf_start, 0);
        chk("R5 two rd_err", rd_err, 1);
        repeat (3) @(negedge clk);
        chk("R5 sticky", rd_err, 1);
        // set and clear together: set wins
        @(negedge clk);
        flag_clr = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_mask = 4'b1111;
        @(negedge clk);
        flag_clr = 1'b0; req_valid = 1'b0;
        chk("R11 set wins", rd_err, 1);
        pulse_clr();
        chk("R11 clr after", rd_err, 0);
    endtask

    task automatic t_hold();
        put_req(1'b1, 4'b0001, 8'h01);
        chk("R7 first ss_n", ss_n, 4'b1110);
        put_req(1'b1, 4'b0010, 8'h02);
        chk("R7 unchanged", ss_n, 4'b1110);
        put_req(1'b1, 4'b1000, 8'h08);
        chk("R7 still unchanged", ss_n, 4'b1110);
        chk("R7 tx unchanged", shf_tx, 8'h01);
        end_xfer(8'h00);
        chk("R7 release gap", ss_n, 4'b1111);
        chk("R7 gap busy", busy, 0);
        @(negedge clk);
        chk("R7 held launched ss_n", ss_n, 4'b0111);
        chk("R7 held start", shf_start, 1);
        chk("R7 latest wins tx", shf_tx, 8'h08);
        end_xfer(8'h00);
        @(negedge clk);
        chk("R7 slot empty", busy, 0);
    endtask

    task automatic t_echo();
        @(negedge clk);
        echo_en = 1'b1;
        xfer(8'h11, 8'h99);
        chk("R10 first skipped", echo_err, 0);
        xfer(8'h22, 8'h11);
        chk("R9 match", echo_err, 0);
        xfer(8'h33, 8'h55);
        chk("R9 mismatch", echo_err, 1);
        xfer(8'h44, 8'h33);
        chk("R9 sticky", echo_err, 1);
        pulse_clr();
        chk("R11 clr echo", echo_err, 0);
        @(negedge clk);
        echo_en = 1'b0;
        repeat (2) @(negedge clk);
        echo_en = 1'b1;
        xfer(8'h66, 8'h00);
        chk("R10 history dropped", echo_err, 0);
        xfer(8'h77, 8'h66);
        chk("R9 match after re-enable", echo_err, 0);
    endtask

    task automatic t_idle_done();
        end_xfer(8'h12);
        chk("R12 ss_n", ss_n, 4'b1111);
        chk("R12 busy", busy, 0);
        chk("R12 start", shf_start, 0);
        chk("R12 echo_err", echo_err, 0);
        xfer(8'h88, 8'h77);
        chk("R12 prev byte kept", echo_err, 0);
        echo_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_mask = '0;
        req_data = '0; echo_en = 1'b0; flag_clr = 1'b0; shf_done = 1'b0; shf_rx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write();
        t_read_ok();
        t_read_bad();
        t_hold();
        t_echo();
        t_idle_done();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule